// File: doc/BRIEF.md
# Multiplier-free Daubechies Analysis Filter Bank

This block performs one level of a one-dimensional Daubechies wavelet analysis on blocks of `N` two's-complement samples. It emits one scaling (low-pass) coefficient and one detail (high-pass) coefficient for every two input samples, so the output stream is decimated by two. A block edge is handled by periodic extension: a window that runs past the last sample takes its missing taps from the start of the same block.

No multipliers are used. Every coefficient is formed bit-serially, one bit position per cycle with the MSB first. The selected bit of every sample in the tap window is gathered into a table address. A table of precomputed coefficient sums, one table per band, returns a partial product. A shift-accumulator doubles its running value and adds the new entry each cycle. The entry taken at the sign position is negated. The parameter `TAPS` selects the 4-tap or the 6-tap filter. Both variants use the same timing.

Samples enter through a valid/ready port that accepts a full block. `in_ready` then stays low until the last coefficient of that block has been taken. Coefficients leave through a valid/ready port. While `out_valid` is high and `out_ready` is low, the coefficient and its band flag are held unchanged.

Top module: `dwt_da_filter`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: The block accepts exactly `N` samples, stored in arrival order as x[0]..x[N-1]. It then holds `in_ready` at 0 until all `N` coefficients of that block have been handed over, and `in_ready` and `out_valid` are never high together.
- R3: The low-pass output of pair p is sum over k of h[k]·x[(2p+k) mod N], exact, as a 17-bit two's-complement integer. The taps are in units of 1/64: the 4-tap set is h = (31, 54, 14, −8) and the 6-tap set is h = (21, 52, 29, −9, −5, 2).
- R4: The high-pass output of pair p uses g[k] = (−1)^k · h[TAPS−1−k] in the same sum.
- R5: Within a block, outputs come out as pair 0 low, pair 0 high, pair 1 low, and so on. `out_high` is 0 on each low-pass word and 1 on each high-pass word.
- R6: The last pairs of a block wrap around: their windows use x[0], x[1], and so on.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_high` stay stable.
- R8: `out_valid` rises exactly `DW` (8) cycles after the last sample of a block is accepted, and exactly `DW` cycles after each output handshake that does not end the block.
- R9: Full-scale inputs (−128 and 127) produce exact results with no overflow. The magnitude never exceeds 128 times the sum of the absolute tap values.
- R10: With `TAPS` = 6, the 6-tap tables are used and the handshake timing is the same as with 4 taps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Block is loading and can take a sample |
| in_data | input | DW | Two's-complement sample |
| out_valid | output | 1 | Coefficient available |
| out_ready | input | 1 | Downstream takes the coefficient |
| out_data | output | CW+DW+1 | Two's-complement coefficient, taps in units of 1/64 |
| out_high | output | 1 | 0 for a low-pass word, 1 for a high-pass word |

## Verification
A slip in the bit-position counter or in the window base changes the value of the very next coefficient. It also moves `out_valid` off its fixed 8-cycle spacing, so the bench sees the error within one coefficient period. A wrong band bit shows up at once in `out_high` and in the value. A wrong wrap index only shows in the final pairs of a block, so every block is checked through its last pair. A sign-position error is invisible for small positive data but large for −128 inputs, which is why full-scale blocks are included.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  typedef enum logic [1:0] {ST_LOAD, ST_CALC, ST_OUT} dwt_state_e;

  // Low-pass taps in units of 1/64.
  function automatic int tap_lo(input int taps, input int k);
    int v;
    v = 0;
    if (taps == 6) begin
      case (k)
        0: v = 21;
        1: v = 52;
        2: v = 29;
        3: v = -9;
        4: v = -5;
        5: v = 2;
        default: v = 0;
      endcase
    end else begin
      case (k)
        0: v = 31;
        1: v = 54;
        2: v = 14;
        3: v = -8;
        default: v = 0;
      endcase
    end
    return v;
  endfunction

  // High-pass taps: reversed low-pass with alternating sign.
  function automatic int tap_coef(input int taps, input int k, input bit high);
    int r;
    if (!high) return tap_lo(taps, k);
    r = tap_lo(taps, taps - 1 - k);
    return (k % 2 == 1) ? -r : r;
  endfunction

  function automatic int table_sum(input int taps, input bit high, input int addr);
    int s;
    s = 0;
    for (int k = 0; k < taps; k++)
      if (((addr >> k) & 1) == 1) s += tap_coef(taps, k, high);
    return s;
  endfunction

  function automatic int abs_tap_sum(input int taps);
    int s;
    s = 0;
    for (int k = 0; k < taps; k++)
      s += (tap_lo(taps, k) < 0) ? -tap_lo(taps, k) : tap_lo(taps, k);
    return s;
  endfunction

endpackage

// File: rtl/dwt_sample_store.sv
module dwt_sample_store #(
  parameter int DW   = 8,
  parameter int N    = 8,
  parameter int TAPS = 4,
  localparam int IW  = (N > 1) ? $clog2(N) : 1,
  localparam int BW  = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic [IW-1:0]   base,
  input  logic [BW-1:0]   bitpos,
  output logic [TAPS-1:0] slice
);

  logic [DW-1:0] mem [N];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  // Window taps wrap modulo N (N is a power of two).
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [IW-1:0] tap_idx;
    assign tap_idx  = base + IW'(k);
    assign slice[k] = mem[tap_idx][bitpos];
  end

endmodule

// File: rtl/dwt_coef_rom.sv
module dwt_coef_rom
  import dwt_pkg::*;
#(
  parameter int TAPS = 4,
  parameter int CW   = 8,
  localparam int DEPTH = 1 << TAPS
) (
  input  logic                 sel_low,
  input  logic [TAPS-1:0]      addr,
  output logic signed [CW-1:0] value
);

  logic signed [CW-1:0] lo_tab [DEPTH];
  logic signed [CW-1:0] hi_tab [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    assign lo_tab[a] = CW'(table_sum(TAPS, 1'b0, a));
    assign hi_tab[a] = CW'(table_sum(TAPS, 1'b1, a));
  end

  assign value = sel_low ? lo_tab[addr] : hi_tab[addr];

endmodule

// File: rtl/dwt_shift_acc.sv
module dwt_shift_acc #(
  parameter int CW = 8,
  parameter int AW = 17
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 first,
  input  logic signed [CW-1:0] term,
  output logic signed [AW-1:0] acc
);

  logic signed [AW-1:0] term_x;
  assign term_x = AW'(term);

  always_ff @(posedge clk) begin
    if (!rst_n)    acc <= '0;
    else if (en)   acc <= first ? -term_x : ((acc <<< 1) + term_x);
  end

endmodule

// File: rtl/dwt_da_filter.sv
module dwt_da_filter
  import dwt_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int N    = 8,
  parameter int TAPS = 4,
  localparam int AW  = CW + DW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_data,
  output logic          out_high
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam int PW = (IW > 1) ? IW - 1 : 1;
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [BW-1:0] BIT_TOP   = BW'(DW - 1);
  localparam logic [PW-1:0] LAST_PAIR = PW'(N / 2 - 1);

  dwt_state_e           state;
  logic [IW-1:0]        wr_cnt;
  logic [PW-1:0]        pair;
  logic                 band;
  logic [BW-1:0]        bitpos;
  logic [TAPS-1:0]      slice;
  logic [IW-1:0]        base;
  logic signed [CW-1:0] term;
  logic signed [AW-1:0] acc;
  logic                 wr_en;

  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_OUT);
  assign out_high  = band;
  assign out_data  = acc;
  assign wr_en     = in_valid && in_ready;
  assign base      = IW'({pair, 1'b0});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_LOAD;
      wr_cnt <= '0;
      pair   <= '0;
      band   <= 1'b0;
      bitpos <= BIT_TOP;
    end else begin
      case (state)
        ST_LOAD: if (wr_en) begin
          wr_cnt <= wr_cnt + 1'b1;
          if (wr_cnt == IW'(N - 1)) begin
            state  <= ST_CALC;
            pair   <= '0;
            band   <= 1'b0;
            bitpos <= BIT_TOP;
          end
        end
        ST_CALC: begin
          if (bitpos == '0) state <= ST_OUT;
          else              bitpos <= bitpos - 1'b1;
        end
        ST_OUT: if (out_ready) begin
          bitpos <= BIT_TOP;
          if (!band) begin
            band  <= 1'b1;
            state <= ST_CALC;
          end else begin
            band <= 1'b0;
            if (pair == LAST_PAIR) begin
              pair  <= '0;
              state <= ST_LOAD;
            end else begin
              pair  <= pair + 1'b1;
              state <= ST_CALC;
            end
          end
        end
        default: state <= ST_LOAD;
      endcase
    end
  end

  dwt_sample_store #(.DW(DW), .N(N), .TAPS(TAPS)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_idx  (wr_cnt),
    .wr_data (in_data),
    .base    (base),
    .bitpos  (bitpos),
    .slice   (slice)
  );

  dwt_coef_rom #(.TAPS(TAPS), .CW(CW)) u_rom (
    .sel_low (~band),
    .addr    (slice),
    .value   (term)
  );

  dwt_shift_acc #(.CW(CW), .AW(AW)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (state == ST_CALC),
    .first (bitpos == BIT_TOP),
    .term  (term),
    .acc   (acc)
  );

endmodule

// File: rtl/dwt_da_checker.sv
module dwt_da_checker
  import dwt_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int N    = 8,
  parameter int TAPS = 4,
  localparam int AW  = CW + DW + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_data,
  input logic          out_high
);

  localparam int BOUND = (1 << (DW - 1)) * abs_tap_sum(TAPS);

  logic band_par;
  always_ff @(posedge clk) begin
    if (!rst_n)                      band_par <= 1'b0;
    else if (out_valid && out_ready) band_par <= ~band_par;
  end

  // R2: loading and emitting never overlap
  p_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R7: held word under back-pressure
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_high)));

  // R8: a new coefficient needs bit-serial cycles after each handshake
  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  // R5: bands alternate, low first
  p_band_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_high == band_par));

  // R9: result stays inside the full-scale bound
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (($signed(out_data) <= BOUND) && ($signed(out_data) >= -BOUND)));

  // R2: no sample is taken while a word is offered
  p_no_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && out_valid) |-> !in_ready);

endmodule

bind dwt_da_filter dwt_da_checker #(.DW(DW), .CW(CW), .N(N), .TAPS(TAPS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_high  (out_high)
);

// File: tb/sim_dwt_da_filter.sv
module sim_dwt_da_filter;
  localparam int N  = 8;
  localparam int DW = 8;
  localparam int AW = 17;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [DW-1:0] in_data = '0;
  logic out_ready = 1;
  logic in_ready0, in_ready1, out_valid0, out_valid1, out_high0, out_high1;
  logic [AW-1:0] out_data0, out_data1;

  always #10 clk = ~clk;

  dwt_da_filter #(.TAPS(4)) u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready0),
    .in_data(in_data), .out_valid(out_valid0), .out_ready(out_ready), .out_data(out_data0), .out_high(out_high0));
  dwt_da_filter #(.TAPS(6)) u1 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready1),
    .in_data(in_data), .out_valid(out_valid1), .out_ready(out_ready), .out_data(out_data1), .out_high(out_high1));

  int checks = 0, fails = 0, cycles = 0;
  bit stall_on = 0, running = 0;

  int h4[4] = '{31, 54, 14, -8};
  int h6[6] = '{21, 52, 29, -9, -5, 2};

  // reference model state
  int m_phase = 0, m_cnt = 0, m_cyc = 0, m_idx = 0;
  int m_x[N];
  bit m_stalled = 0;

  function automatic int hcoef(int taps, int k);
    return (taps == 6) ? h6[k] : h4[k];
  endfunction

  function automatic int expect_val(int taps, int idx);
    int s, p, c;
    s = 0; p = idx / 2;
    for (int k = 0; k < taps; k++) begin
      if (idx % 2 == 0) c = hcoef(taps, k);
      else c = (k % 2 == 1) ? -hcoef(taps, taps - 1 - k) : hcoef(taps, taps - 1 - k);
      s += c * m_x[(2 * p + k) % N];
    end
    return s;
  endfunction

  function automatic bit full_scale();
    for (int i = 0; i < N; i++) if (m_x[i] != 127 && m_x[i] != -128) return 0;
    return 1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // model update
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      report();
    end
    if (rst_n) begin
      m_stalled = (m_phase == 2) && !out_ready;
      case (m_phase)
        0: if (in_valid) begin
          m_x[m_cnt] = $signed(in_data);
          m_cnt++;
          if (m_cnt == N) begin m_phase = 1; m_cyc = 0; m_idx = 0; end
        end
        1: begin m_cyc++; if (m_cyc == DW) m_phase = 2; end
        default: if (out_ready) begin
          m_idx++;
          if (m_idx == N) begin m_phase = 0; m_cnt = 0; end
          else begin m_phase = 1; m_cyc = 0; end
        end
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (running) begin
      string tag;
      chk(in_ready0 == (m_phase == 0), "R2 in_ready", in_ready0, m_phase == 0);
      chk(in_ready1 == (m_phase == 0), "R10 in_ready", in_ready1, m_phase == 0);
      chk(out_valid0 == (m_phase == 2), "R8 out_valid", out_valid0, m_phase == 2);
      chk(out_valid1 == (m_phase == 2), "R10 out_valid", out_valid1, m_phase == 2);
      if (m_phase == 2) begin
        if (full_scale())               tag = "R9";
        else if (m_stalled)             tag = "R7";
        else if (m_idx / 2 == N/2 - 1)  tag = "R6";
        else if (m_idx % 2 == 1)        tag = "R4";
        else                            tag = "R3";
        chk($signed(out_data0) == expect_val(4, m_idx), tag, $signed(out_data0), expect_val(4, m_idx));
        chk($signed(out_data1) == expect_val(6, m_idx), {"R10 ", tag}, $signed(out_data1), expect_val(6, m_idx));
        chk(out_high0 == m_idx[0], "R5 out_high", out_high0, m_idx % 2);
        chk(out_high1 == m_idx[0], "R10 R5 out_high", out_high1, m_idx % 2);
      end
    end
    if (stall_on) out_ready = ($urandom_range(0, 2) != 0);
    else          out_ready = 1;
  end

  task automatic send_block(int kind, bit gaps);
    for (int i = 0; i < N; i++) begin
      int v;
      case (kind)
        0: v = i * 17 - 60;
        1: v = -128;
        2: v = (i % 2 == 0) ? 127 : -128;
        3: v = 127;
        default: v = $urandom_range(0, 255) - 128;
      endcase
      if (gaps && $urandom_range(0, 1) == 1) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1;
      in_data  = DW'(v);
      do @(posedge clk); while (!in_ready0);
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready0 == 1 && in_ready1 == 1, "R1 in_ready", in_ready0, 1);
    chk(out_valid0 == 0 && out_valid1 == 0, "R1 out_valid", out_valid0, 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready0 == 1, "R1 in_ready after release", in_ready0, 1);
    running = 1;
    send_block(0, 0);
    send_block(1, 0);
    send_block(2, 1);
    send_block(3, 0);
    stall_on = 1;
    send_block(0, 1);
    send_block(1, 1);
    for (int b = 0; b < 12; b++) send_block(4, b % 2 == 1);
    stall_on = 0;
    for (int b = 0; b < 4; b++) send_block(4, 0);
    while (!(m_phase == 0 && m_cnt == 0)) @(negedge clk);
    @(negedge clk);
    report();
  end

endmodule